// File: doc/BRIEF.md
# Leaky Bucket Packet Policer

This block polices packet arrivals on many channels with a leaky bucket per channel. Each channel keeps a bucket level, the time of its last arrival, a drain rate and a ceiling. When a packet arrives, the block first drains the bucket in one step. The drain is the time since the last arrival multiplied by the channel's rate, and the bucket never goes below empty. The block then charges the packet's size to the bucket. If the new level would rise above the ceiling, the packet is dropped and a policing-error event is raised. A dropped packet is never charged to the bucket.

A request carries a channel, a size and a 24-bit arrival time. One cycle later the block returns a single-cycle verdict strobe and, on a drop, an event strobe. Each channel also keeps a count of accepted packets and of accepted octets, and both counts wrap on overflow. Software-side setup writes the ceiling and rate of one channel at a time. A read port shows any channel's level, stamp and counts.

Top module: `leaky_policer`

## Requirements
- R1: After reset every channel has level 0, stamp 0, packet count 0, octet count 0, ceiling 0 and rate 0, and resp_valid and evt_valid are low.
- R2: A request on req_valid produces resp_valid high for exactly the following cycle, with resp_ch equal to the request's channel. No response appears without a request.
- R3: The drain is ((req_ts - stored stamp) mod 2^24) times the rate, saturated at 2^22-1. The drained level is the stored level minus the drain, or 0 if the drain is at least the level.
- R4: If the drained level plus req_size is at most the channel's ceiling (compared as unsigned numbers), the packet is accepted (resp_accept=1) and the stored level becomes that sum.
- R5: If the sum exceeds the ceiling, resp_accept=0, evt_valid=1 with evt_police_err=1 and evt_ch set to the channel, and the stored level becomes the drained level.
- R6: The stored stamp becomes req_ts on every request, whether the packet is accepted or dropped.
- R7: The 16-bit packet count of the channel increases by one on an accepted packet only.
- R8: The 32-bit octet count of the channel increases by req_size on an accepted packet only.
- R9: A request changes only the state of its own channel.
- R10: A setup write (cfg_we) sets the ceiling and rate of cfg_ch. It leaves that channel's level, stamp and counts unchanged.
- R11: The elapsed time is taken modulo 2^24, so an arrival whose stamp has wrapped past zero drains by the true short interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet arrival request |
| req_ch | input | 4 | Channel of the arriving packet |
| req_size | input | 16 | Packet size in octets |
| req_ts | input | 24 | Arrival time stamp |
| cfg_we | input | 1 | Setup write strobe |
| cfg_ch | input | 4 | Channel being set up |
| cfg_max_fill | input | 16 | Bucket ceiling |
| cfg_rate | input | 6 | Drain per time unit |
| rd_ch | input | 4 | Channel shown on the read port |
| rd_fill | output | 22 | Bucket level of rd_ch |
| rd_last_ts | output | 24 | Last arrival stamp of rd_ch |
| rd_pkt_cnt | output | 16 | Accepted packet count of rd_ch |
| rd_oct_cnt | output | 32 | Accepted octet count of rd_ch |
| resp_valid | output | 1 | Verdict strobe |
| resp_accept | output | 1 | 1 = accepted, 0 = dropped |
| resp_ch | output | 4 | Channel of the verdict |
| evt_valid | output | 1 | Event strobe |
| evt_ch | output | 4 | Channel of the event |
| evt_police_err | output | 1 | Policing-error bit of the event |

## Verification
The assertions assume a channel is never set up in the same cycle as a request on that channel. They also assume req_ch and cfg_ch always name a channel that exists. Under those assumptions, a verdict always follows its request and a drop always raises an event. The stimulus never puts a setup write and a request in the same cycle, and uses channel numbers below the channel count. Arrival stamps per channel either increase or wrap deliberately past 2^24.

// File: rtl/pol_pkg.sv
package pol_pkg;
  parameter int DEF_NUM_CH = 16;
  parameter int DEF_FILL_W = 22;
  parameter int DEF_MAXF_W = 16;
  parameter int DEF_RATE_W = 6;
  parameter int DEF_TS_W   = 24;
  parameter int DEF_SIZE_W = 16;
  parameter int DEF_PKT_W  = 16;
  parameter int DEF_OCT_W  = 32;

  typedef enum logic {VERDICT_DROP = 1'b0, VERDICT_PASS = 1'b1} verdict_e;
endpackage

// File: rtl/policer_calc.sv
module policer_calc #(
  parameter int FILL_W = 22,
  parameter int MAXF_W = 16,
  parameter int RATE_W = 6,
  parameter int TS_W   = 24,
  parameter int SIZE_W = 16
) (
  input  logic [FILL_W-1:0] cur_fill,
  input  logic [TS_W-1:0]   cur_last_ts,
  input  logic [MAXF_W-1:0] cur_max,
  input  logic [RATE_W-1:0] cur_rate,
  input  logic [TS_W-1:0]   pkt_ts,
  input  logic [SIZE_W-1:0] pkt_size,
  output logic [FILL_W-1:0] drained_fill,
  output logic              accept,
  output logic [FILL_W-1:0] next_fill
);
  localparam int PROD_W = TS_W + RATE_W;
  localparam int SUM_W  = FILL_W + 1;
  localparam logic [PROD_W-1:0] FILL_CAP = PROD_W'({FILL_W{1'b1}});

  function automatic logic [FILL_W-1:0] drain_amount(input logic [TS_W-1:0] elapsed,
                                                     input logic [RATE_W-1:0] rate);
    logic [PROD_W-1:0] prod;
    prod = PROD_W'(elapsed) * PROD_W'(rate);
    if (prod > FILL_CAP) return {FILL_W{1'b1}};
    return prod[FILL_W-1:0];
  endfunction

  function automatic logic [FILL_W-1:0] floor_sub(input logic [FILL_W-1:0] level,
                                                  input logic [FILL_W-1:0] amt);
    if (amt >= level) return '0;
    return level - amt;
  endfunction

  logic [TS_W-1:0]   elapsed;
  logic [FILL_W-1:0] drain;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    elapsed      = pkt_ts - cur_last_ts;
    drain        = drain_amount(elapsed, cur_rate);
    drained_fill = floor_sub(cur_fill, drain);
    sum          = {1'b0, drained_fill} + SUM_W'(pkt_size);
    accept       = (sum <= SUM_W'(cur_max));
    next_fill    = accept ? sum[FILL_W-1:0] : drained_fill;
  end
endmodule

// File: rtl/policer_ctx_store.sv
module policer_ctx_store #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int FILL_W = 22,
  parameter int MAXF_W = 16,
  parameter int RATE_W = 6,
  parameter int TS_W   = 24,
  parameter int SIZE_W = 16,
  parameter int PKT_W  = 16,
  parameter int OCT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [CH_W-1:0]   upd_ch,
  input  logic              upd_accept,
  input  logic [FILL_W-1:0] upd_fill,
  input  logic [TS_W-1:0]   upd_ts,
  input  logic [SIZE_W-1:0] upd_size,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [MAXF_W-1:0] cfg_max,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [CH_W-1:0]   lk_ch,
  output logic [FILL_W-1:0] lk_fill,
  output logic [TS_W-1:0]   lk_ts,
  output logic [MAXF_W-1:0] lk_max,
  output logic [RATE_W-1:0] lk_rate,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [FILL_W-1:0] rd_fill,
  output logic [TS_W-1:0]   rd_ts,
  output logic [PKT_W-1:0]  rd_pkt,
  output logic [OCT_W-1:0]  rd_oct
);
  logic [FILL_W-1:0] fill_a [NUM_CH];
  logic [TS_W-1:0]   ts_a   [NUM_CH];
  logic [MAXF_W-1:0] max_a  [NUM_CH];
  logic [RATE_W-1:0] rate_a [NUM_CH];
  logic [PKT_W-1:0]  pkt_a  [NUM_CH];
  logic [OCT_W-1:0]  oct_a  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic              upd_hit, cfg_hit;
    logic [FILL_W-1:0] fill_r;
    logic [TS_W-1:0]   ts_r;
    logic [MAXF_W-1:0] max_r;
    logic [RATE_W-1:0] rate_r;
    logic [PKT_W-1:0]  pkt_r;
    logic [OCT_W-1:0]  oct_r;

    assign upd_hit = upd_en && (upd_ch == CH_W'(g));
    assign cfg_hit = cfg_we && (cfg_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fill_r <= '0;
        ts_r   <= '0;
        max_r  <= '0;
        rate_r <= '0;
        pkt_r  <= '0;
        oct_r  <= '0;
      end else begin
        if (cfg_hit) begin
          max_r  <= cfg_max;
          rate_r <= cfg_rate;
        end
        if (upd_hit) begin
          fill_r <= upd_fill;
          ts_r   <= upd_ts;
          if (upd_accept) begin
            pkt_r <= pkt_r + 1'b1;
            oct_r <= oct_r + OCT_W'(upd_size);
          end
        end
      end
    end

    assign fill_a[g] = fill_r;
    assign ts_a[g]   = ts_r;
    assign max_a[g]  = max_r;
    assign rate_a[g] = rate_r;
    assign pkt_a[g]  = pkt_r;
    assign oct_a[g]  = oct_r;
  end

  assign lk_fill = fill_a[lk_ch];
  assign lk_ts   = ts_a[lk_ch];
  assign lk_max  = max_a[lk_ch];
  assign lk_rate = rate_a[lk_ch];
  assign rd_fill = fill_a[rd_ch];
  assign rd_ts   = ts_a[rd_ch];
  assign rd_pkt  = pkt_a[rd_ch];
  assign rd_oct  = oct_a[rd_ch];
endmodule

// File: rtl/leaky_policer.sv
module leaky_policer #(
  parameter int NUM_CH = pol_pkg::DEF_NUM_CH,
  parameter int FILL_W = pol_pkg::DEF_FILL_W,
  parameter int MAXF_W = pol_pkg::DEF_MAXF_W,
  parameter int RATE_W = pol_pkg::DEF_RATE_W,
  parameter int TS_W   = pol_pkg::DEF_TS_W,
  parameter int SIZE_W = pol_pkg::DEF_SIZE_W,
  parameter int PKT_W  = pol_pkg::DEF_PKT_W,
  parameter int OCT_W  = pol_pkg::DEF_OCT_W,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_ch,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [TS_W-1:0]   req_ts,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [MAXF_W-1:0] cfg_max_fill,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [FILL_W-1:0] rd_fill,
  output logic [TS_W-1:0]   rd_last_ts,
  output logic [PKT_W-1:0]  rd_pkt_cnt,
  output logic [OCT_W-1:0]  rd_oct_cnt,
  output logic              resp_valid,
  output logic              resp_accept,
  output logic [CH_W-1:0]   resp_ch,
  output logic              evt_valid,
  output logic [CH_W-1:0]   evt_ch,
  output logic              evt_police_err
);
  import pol_pkg::*;

  // Lookup of the requesting channel's context
  logic [FILL_W-1:0] cur_fill;
  logic [TS_W-1:0]   cur_last_ts;
  logic [MAXF_W-1:0] cur_max;
  logic [RATE_W-1:0] cur_rate;

  // Decision results, named for the checker
  logic [FILL_W-1:0] drained_fill;
  logic [FILL_W-1:0] next_fill;
  logic              dec_accept;

  verdict_e          verdict_q;
  logic              resp_valid_q;
  logic [CH_W-1:0]   resp_ch_q;

  policer_ctx_store #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .FILL_W(FILL_W), .MAXF_W(MAXF_W),
    .RATE_W(RATE_W), .TS_W(TS_W), .SIZE_W(SIZE_W), .PKT_W(PKT_W), .OCT_W(OCT_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (req_valid),
    .upd_ch     (req_ch),
    .upd_accept (dec_accept),
    .upd_fill   (next_fill),
    .upd_ts     (req_ts),
    .upd_size   (req_size),
    .cfg_we     (cfg_we),
    .cfg_ch     (cfg_ch),
    .cfg_max    (cfg_max_fill),
    .cfg_rate   (cfg_rate),
    .lk_ch      (req_ch),
    .lk_fill    (cur_fill),
    .lk_ts      (cur_last_ts),
    .lk_max     (cur_max),
    .lk_rate    (cur_rate),
    .rd_ch      (rd_ch),
    .rd_fill    (rd_fill),
    .rd_ts      (rd_last_ts),
    .rd_pkt     (rd_pkt_cnt),
    .rd_oct     (rd_oct_cnt)
  );

  policer_calc #(
    .FILL_W(FILL_W), .MAXF_W(MAXF_W), .RATE_W(RATE_W), .TS_W(TS_W), .SIZE_W(SIZE_W)
  ) u_calc (
    .cur_fill     (cur_fill),
    .cur_last_ts  (cur_last_ts),
    .cur_max      (cur_max),
    .cur_rate     (cur_rate),
    .pkt_ts       (req_ts),
    .pkt_size     (req_size),
    .drained_fill (drained_fill),
    .accept       (dec_accept),
    .next_fill    (next_fill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_ch_q    <= '0;
      verdict_q    <= VERDICT_DROP;
    end else begin
      resp_valid_q <= req_valid;
      if (req_valid) begin
        resp_ch_q <= req_ch;
        verdict_q <= dec_accept ? VERDICT_PASS : VERDICT_DROP;
      end
    end
  end

  assign resp_valid     = resp_valid_q;
  assign resp_accept    = resp_valid_q && (verdict_q == VERDICT_PASS);
  assign resp_ch        = resp_ch_q;
  assign evt_valid      = resp_valid_q && (verdict_q == VERDICT_DROP);
  assign evt_police_err = evt_valid;
  assign evt_ch         = resp_ch_q;
endmodule

// File: rtl/policer_checker.sv
module policer_checker #(
  parameter int CH_W   = 4,
  parameter int FILL_W = 22,
  parameter int MAXF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CH_W-1:0]   req_ch,
  input logic              resp_valid,
  input logic              resp_accept,
  input logic [CH_W-1:0]   resp_ch,
  input logic              evt_valid,
  input logic [CH_W-1:0]   evt_ch,
  input logic              evt_police_err,
  input logic [FILL_W-1:0] cur_fill,
  input logic [MAXF_W-1:0] cur_max,
  input logic [FILL_W-1:0] drained_fill,
  input logic [FILL_W-1:0] next_fill,
  input logic              dec_accept
);
  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  a_r2_resp_channel: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (resp_ch == $past(req_ch)));

  a_r5_event_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (evt_valid == !resp_accept));

  a_r5_event_fields: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_police_err && resp_valid && evt_ch == resp_ch));

  a_r3_drain_never_adds: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (drained_fill <= cur_fill));

  a_r4_accept_within_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dec_accept) |-> (next_fill <= FILL_W'(cur_max)));

  a_r5_drop_not_charged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dec_accept) |-> (next_fill == drained_fill));
endmodule

bind leaky_policer policer_checker #(
  .CH_W(CH_W), .FILL_W(FILL_W), .MAXF_W(MAXF_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ch         (req_ch),
  .resp_valid     (resp_valid),
  .resp_accept    (resp_accept),
  .resp_ch        (resp_ch),
  .evt_valid      (evt_valid),
  .evt_ch         (evt_ch),
  .evt_police_err (evt_police_err),
  .cur_fill       (cur_fill),
  .cur_max        (cur_max),
  .drained_fill   (drained_fill),
  .next_fill      (next_fill),
  .dec_accept     (dec_accept)
);

// File: tb/tb_leaky_policer.sv
module tb_leaky_policer;
  localparam int NCH = 16;
  localparam int CHW = 4;
  localparam longint TS_MOD   = 64'h1000000;
  localparam longint FILL_TOP = 64'h3FFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_ch = '0;
  logic [15:0] req_size = '0;
  logic [23:0] req_ts = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_ch = '0;
  logic [15:0] cfg_max_fill = '0;
  logic [5:0]  cfg_rate = '0;
  logic [3:0]  rd_ch = '0;
  logic [21:0] rd_fill;
  logic [23:0] rd_last_ts;
  logic [15:0] rd_pkt_cnt;
  logic [31:0] rd_oct_cnt;
  logic        resp_valid, resp_accept, evt_valid, evt_police_err;
  logic [3:0]  resp_ch, evt_ch;

  leaky_policer dut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference context, kept independently of the design
  longint m_fill [NCH];
  longint m_ts   [NCH];
  longint m_max  [NCH];
  longint m_rate [NCH];
  longint m_pkt  [NCH];
  longint m_oct  [NCH];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_ctx(int ch, string tag);
    rd_ch = ch[CHW-1:0];
    #1;
    chk({tag, " level"}, rd_fill, m_fill[ch]);
    chk({tag, " stamp"}, rd_last_ts, m_ts[ch]);
    chk({tag, " pkt count (R7)"}, rd_pkt_cnt, m_pkt[ch]);
    chk({tag, " octet count (R8)"}, rd_oct_cnt, m_oct[ch]);
  endtask

  task automatic setup(int ch, int ceil, int rate);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch[CHW-1:0];
    cfg_max_fill = ceil[15:0]; cfg_rate = rate[5:0];
    @(negedge clk);
    cfg_we = 1'b0;
    m_max[ch] = ceil; m_rate[ch] = rate;
    check_ctx(ch, "R10 setup keeps state");
  endtask

  // One arrival; returns the expected verdict
  task automatic arrive(int ch, int size, longint ts, string tag, output bit exp_acc);
    longint el, dr, drained, total;
    el = (ts - m_ts[ch]) % TS_MOD;
    if (el < 0) el += TS_MOD;
    dr = el * m_rate[ch];
    if (dr > FILL_TOP) dr = FILL_TOP;
    drained = (dr >= m_fill[ch]) ? 0 : m_fill[ch] - dr;
    total = drained + size;
    exp_acc = (total <= m_max[ch]);
    @(negedge clk);
    req_valid = 1'b1; req_ch = ch[CHW-1:0];
    req_size = size[15:0]; req_ts = ts[23:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 resp_valid"}, resp_valid, 1);
    chk({tag, " R2 resp_ch"}, resp_ch, ch);
    chk({tag, " R4/R5 verdict"}, resp_accept, exp_acc);
    chk({tag, " R5 evt_valid"}, evt_valid, !exp_acc);
    if (!exp_acc) begin
      chk({tag, " R5 error bit"}, evt_police_err, 1);
      chk({tag, " R5 evt_ch"}, evt_ch, ch);
    end
    m_fill[ch] = exp_acc ? total : drained;
    m_ts[ch] = ts % TS_MOD;
    if (exp_acc) begin
      m_pkt[ch] = (m_pkt[ch] + 1) % 64'h10000;
      m_oct[ch] = (m_oct[ch] + size) % 64'h100000000;
    end
    check_ctx(ch, {tag, " R6"});
    @(negedge clk);
    chk({tag, " R2 single-cycle strobe"}, resp_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 resp_valid after reset", resp_valid, 0);
    chk("R1 evt_valid after reset", evt_valid, 0);
    for (int c = 0; c < NCH; c++) check_ctx(c, "R1 reset");
  endtask

  task automatic t_basic();
    bit a;
    setup(0, 1000, 2);
    arrive(0, 300, 10, "R4 first accept", a);
    chk("R4 first packet passes", a, 1);
    arrive(0, 100, 60, "R3 drain 100", a);
    chk("R3 level after drain", m_fill[0], 300);
  endtask

  task automatic t_drop();
    bit a;
    arrive(0, 900, 70, "R5 overflow drop", a);
    chk("R5 drop expected", a, 0);
    chk("R5 level keeps drained value", m_fill[0], 280);
  endtask

  task automatic t_clamp();
    bit a;
    arrive(0, 1000, 100000, "R3 clamp, R4 exactly ceiling", a);
    chk("R4 size equal to ceiling passes", a, 1);
    arrive(0, 1, 100000, "R4 one over ceiling", a);
    chk("R4 one over drops", a, 0);
  endtask

  task automatic t_saturate();
    bit a;
    setup(1, 2000, 16);
    arrive(1, 500, 0, "R3 load", a);
    // elapsed 2^18+1 at rate 16 exceeds the level width: drain saturates
    arrive(1, 1500, 262145, "R3 saturated drain", a);
    chk("R3 saturation empties bucket", m_fill[1], 1500);
  endtask

  task automatic t_wrap();
    bit a;
    setup(2, 5000, 1);
    arrive(2, 1000, 64'hFFFFF0, "R11 before wrap", a);
    arrive(2, 10, 64'h10, "R11 after wrap", a);
    chk("R11 short interval drain", m_fill[2], 978);
  endtask

  task automatic t_channels();
    bit a;
    setup(3, 50, 0);
    arrive(3, 40, 5, "R9 ch3 accept", a);
    arrive(3, 20, 6, "R9 ch3 drop, no drain", a);
    chk("R9 ch3 drop", a, 0);
    check_ctx(0, "R9 ch0 untouched");
    check_ctx(1, "R9 ch1 untouched");
    setup(3, 100, 3);
    check_ctx(3, "R10 ch3 after resetup");
  endtask

  task automatic t_burst();
    bit a;
    for (int i = 0; i < 20; i++) begin
      arrive(4 + (i % 3), 37 * (i + 1), 200 + 3 * i, "R7 burst", a);
    end
    setup(7, 65535, 63);
    for (int i = 0; i < 6; i++) arrive(7, 30000, 1000 + i, "R8 octet sum", a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      m_fill[c] = 0; m_ts[c] = 0; m_max[c] = 0;
      m_rate[c] = 0; m_pkt[c] = 0; m_oct[c] = 0;
    end
    t_reset();
    t_basic();
    t_drop();
    t_clamp();
    t_saturate();
    t_wrap();
    t_channels();
    t_burst();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule